// File: doc/BRIEF.md
# Protection Fault Sequencer

This block is the supervisory state machine of a primary-side switching-converter controller. It receives already-digitized comparator flags: three supply levels, supply overvoltage, two shutdown-pin conditions with a restart-level flag, winding short, auxiliary-pin short, current-sense-pin short, brown-out and die overtemperature. From these it decides when the power switch may be driven and when the supply pin draws start-up current. All timing is counted on a prescaled `tick` input. Each time constant is a parameter, so the long real-world windows can be shrunk for simulation.

The six states, with the `seq_state` encoding, are RESET (0), STOP (1), RUN (2), DISCH (3, supply discharge), AUTOREC (4, auto-recovery timer) and LATCHED (5). The transitions are as follows.
- Power-up: RESET goes to STOP once the start delay has elapsed. STOP goes to RUN when the block is clear to switch.
- Undervoltage: STOP, RUN and DISCH go to RESET.
- Faults: STOP and RUN go to AUTOREC, DISCH or LATCHED, depending on which fault was taken.
- Recovery: DISCH goes to RESET on the supply hiccup, or at once when a brown-out ends. AUTOREC goes to RESET when its timer has expired and the supply is ready. LATCHED goes to RESET only on the supply-reset flag.

A parameter chooses between the auto-restart variant and the latched variant. A 4-bit fault code holds the cause of the last shutdown.

Top module: `prot_seq`

## Requirements
- R1: While `rst_n` is low and right after it rises, `seq_state` is 0 (RESET), `gate_en` is 0, `startup_cur` is 1 and `fault_code` is 0.
- R2: In RESET, the block leaves for STOP after START_TICKS clock cycles with `tick` high while `supply_on` is held high. Cycles with `tick` low are not counted. STOP moves to RUN on the next cycle when `brownout` and `die_hot` are low and `sd_restart_ok` is high. `gate_en` is 1 only in RUN.
- R3: `below_off` high in STOP, RUN or DISCH sends the block to RESET on the next clock. This does not change `fault_code`.
- R4: `sd_ov` and `sd_ot` are accepted only after they stay high for CONFIRM_TICKS ticks in STOP or RUN. A shorter pulse has no effect.
- R5: `aux_short` must persist for AUX_TICKS ticks. `brownout` must persist for BO_LONG_TICKS ticks, or for BO_SHORT_TICKS ticks when BO_SHORT is 1.
- R6: `supply_ov` and a confirmed `sd_ov` lead to AUTOREC. A CS short, `die_hot` and a confirmed brown-out lead to DISCH. Winding short, confirmed overtemperature and confirmed aux short lead to AUTOREC when LATCHED is 0.
- R7: AUTOREC counts RECOVER_TICKS ticks. It moves to RESET only after that count and with `supply_on` high. After an overtemperature fault it also requires `sd_restart_ok`.
- R8: With LATCHED=1, winding short, overtemperature and aux short lead to LATCHED. The block leaves LATCHED only when `below_reset` is high.
- R9: In DISCH after a brown-out fault, the block moves to RESET on the clock after `brownout` falls, even while `below_off` is low.
- R10: For every other DISCH cause, the block stays in DISCH until `below_off` is high, and then moves to RESET.
- R11: A CS short is taken only in RUN, with `on_blank_done` and `cs_low` both high, and only when CS_CHECK_EN is 1.
- R12: When several faults are present together, the order of precedence is winding short, overtemperature, aux short, supply overvoltage, SD overvoltage, CS short, die heat, brown-out. Fault codes: 1 supply OV, 2 SD OV, 3 SD OT, 4 winding, 5 aux, 6 CS, 7 die, 8 brown-out.
- R13: In AUTOREC and LATCHED, `startup_cur` is 0 until `below_off` is seen high. From the next clock it is 1, and it returns to 0 after `supply_on` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled timebase enable |
| supply_on | input | 1 | Supply at or above its on-level |
| below_off | input | 1 | Supply below its off-level |
| below_reset | input | 1 | Supply below its reset level |
| supply_ov | input | 1 | Supply overvoltage |
| sd_ov | input | 1 | Shutdown-pin overvoltage (raw) |
| sd_ot | input | 1 | Shutdown-pin overtemperature (raw) |
| sd_restart_ok | input | 1 | Shutdown pin above its restart level |
| winding_short | input | 1 | Winding/diode short comparator |
| aux_short | input | 1 | Auxiliary pin low (raw) |
| cs_low | input | 1 | Current sense below its low threshold |
| on_blank_done | input | 1 | Switch on-time beyond the blanking window |
| brownout | input | 1 | Line below brown-out level (raw) |
| die_hot | input | 1 | Die overtemperature |
| gate_en | output | 1 | Switching allowed |
| startup_cur | output | 1 | Select start-up supply current |
| fault_code | output | 4 | Cause of last shutdown |
| seq_state | output | 3 | Current state |

## Verification
Several rules are checked on every cycle by properties:
- undervoltage in RUN always lands in RESET;
- LATCHED holds without the reset flag;
- a brown-out exit goes straight to RESET;
- AUTOREC never leaves while the supply is low;
- switching only ever begins from STOP.

Only the bench scenarios can show the counted windows, the effect of the variant parameters and the precedence between simultaneous faults. These cover the start delay, the confirmation and persistence times, the recovery time, the overtemperature hysteresis, the CS blanking gate and the start-up-current hiccup pattern.

// File: rtl/psq_pkg.sv
package psq_pkg;
    typedef enum logic [2:0] {
        ST_RESET   = 3'd0,
        ST_STOP    = 3'd1,
        ST_RUN     = 3'd2,
        ST_DISCH   = 3'd3,
        ST_AUTOREC = 3'd4,
        ST_LATCHED = 3'd5
    } seq_state_t;

    typedef enum logic [3:0] {
        FC_NONE      = 4'd0,
        FC_SUPPLY_OV = 4'd1,
        FC_SD_OV     = 4'd2,
        FC_SD_OT     = 4'd3,
        FC_WINDING   = 4'd4,
        FC_AUX       = 4'd5,
        FC_CS        = 4'd6,
        FC_DIE       = 4'd7,
        FC_BROWNOUT  = 4'd8
    } fault_code_t;
endpackage

// File: rtl/psq_persist.sv
// Counts ticks while enabled and the level is high; clears otherwise.
module psq_persist #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic en,
    input  logic level,
    output logic reached
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!(en && level))
            cnt <= '0;
        else if (tick && cnt != LIM)
            cnt <= cnt + 1'b1;
    end

    assign reached = en && level && (cnt == LIM);
endmodule

// File: rtl/psq_fault_arb.sv
// Picks one fault by fixed precedence and its destination state.
module psq_fault_arb
    import psq_pkg::*;
#(
    parameter bit LATCHED = 1'b0
) (
    input  logic        winding,
    input  logic        sd_ot_ok,
    input  logic        aux_ok,
    input  logic        supply_ov,
    input  logic        sd_ov_ok,
    input  logic        cs_hit,
    input  logic        die_hot,
    input  logic        bo_ok,
    output logic        hit,
    output fault_code_t code,
    output seq_state_t  dest
);
    localparam seq_state_t HARD_DEST = LATCHED ? ST_LATCHED : ST_AUTOREC;

    always_comb begin
        hit  = 1'b1;
        code = FC_NONE;
        dest = ST_AUTOREC;
        if (winding) begin
            code = FC_WINDING;   dest = HARD_DEST;
        end else if (sd_ot_ok) begin
            code = FC_SD_OT;     dest = HARD_DEST;
        end else if (aux_ok) begin
            code = FC_AUX;       dest = HARD_DEST;
        end else if (supply_ov) begin
            code = FC_SUPPLY_OV; dest = ST_AUTOREC;
        end else if (sd_ov_ok) begin
            code = FC_SD_OV;     dest = ST_AUTOREC;
        end else if (cs_hit) begin
            code = FC_CS;        dest = ST_DISCH;
        end else if (die_hot) begin
            code = FC_DIE;       dest = ST_DISCH;
        end else if (bo_ok) begin
            code = FC_BROWNOUT;  dest = ST_DISCH;
        end else begin
            hit  = 1'b0;
        end
    end
endmodule

// File: rtl/prot_seq.sv
module prot_seq
    import psq_pkg::*;
#(
    parameter int START_TICKS    = 24,
    parameter int CONFIRM_TICKS  = 3,
    parameter int AUX_TICKS      = 9000,
    parameter int BO_LONG_TICKS  = 5000,
    parameter int BO_SHORT_TICKS = 1500,
    parameter bit BO_SHORT       = 1'b0,
    parameter int RECOVER_TICKS  = 400000,
    parameter bit LATCHED        = 1'b0,
    parameter bit CS_CHECK_EN    = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       supply_on,
    input  logic       below_off,
    input  logic       below_reset,
    input  logic       supply_ov,
    input  logic       sd_ov,
    input  logic       sd_ot,
    input  logic       sd_restart_ok,
    input  logic       winding_short,
    input  logic       aux_short,
    input  logic       cs_low,
    input  logic       on_blank_done,
    input  logic       brownout,
    input  logic       die_hot,
    output logic       gate_en,
    output logic       startup_cur,
    output logic [3:0] fault_code,
    output logic [2:0] seq_state
);
    localparam int BO_TICKS  = BO_SHORT ? BO_SHORT_TICKS : BO_LONG_TICKS;
    localparam int N_FILT    = 4;
    localparam int FLT_LIM [N_FILT] = '{CONFIRM_TICKS, CONFIRM_TICKS, AUX_TICKS, BO_TICKS};

    seq_state_t  state, nxt;
    fault_code_t code_q, arb_code;
    seq_state_t  arb_dest;
    logic        arb_hit, watch, cs_hit, start_done, rec_done, hiccup;
    logic [N_FILT-1:0] raw_flag, flt_ok;

    assign watch    = (state == ST_STOP) || (state == ST_RUN);
    assign raw_flag = {brownout, aux_short, sd_ot, sd_ov};

    // Persistence filters: SD overvoltage, SD overtemperature, aux short, brown-out
    for (genvar g = 0; g < N_FILT; g++) begin : g_filt
        psq_persist #(.LIMIT(FLT_LIM[g])) u_filt (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .en(watch), .level(raw_flag[g]), .reached(flt_ok[g])
        );
    end

    psq_persist #(.LIMIT(START_TICKS)) u_start (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .en(state == ST_RESET), .level(supply_on), .reached(start_done)
    );

    psq_persist #(.LIMIT(RECOVER_TICKS)) u_recover (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .en(state == ST_AUTOREC), .level(1'b1), .reached(rec_done)
    );

    assign cs_hit = CS_CHECK_EN && (state == ST_RUN) && on_blank_done && cs_low;

    psq_fault_arb #(.LATCHED(LATCHED)) u_arb (
        .winding(winding_short), .sd_ot_ok(flt_ok[1]), .aux_ok(flt_ok[2]),
        .supply_ov(supply_ov), .sd_ov_ok(flt_ok[0]), .cs_hit(cs_hit),
        .die_hot(die_hot), .bo_ok(flt_ok[3]),
        .hit(arb_hit), .code(arb_code), .dest(arb_dest)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RESET:   if (start_done) nxt = ST_STOP;
            ST_STOP: begin
                if (below_off)      nxt = ST_RESET;
                else if (arb_hit)   nxt = arb_dest;
                else if (!brownout && !die_hot && sd_restart_ok) nxt = ST_RUN;
            end
            ST_RUN: begin
                if (below_off)      nxt = ST_RESET;
                else if (arb_hit)   nxt = arb_dest;
            end
            ST_DISCH:
                if (below_off || (code_q == FC_BROWNOUT && !brownout)) nxt = ST_RESET;
            ST_AUTOREC:
                if (rec_done && supply_on && (code_q != FC_SD_OT || sd_restart_ok))
                    nxt = ST_RESET;
            ST_LATCHED: if (below_reset) nxt = ST_RESET;
            default:    nxt = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_RESET;
            code_q <= FC_NONE;
            hiccup <= 1'b0;
        end else begin
            state <= nxt;
            if (watch && !below_off && arb_hit)
                code_q <= arb_code;
            if (below_off)
                hiccup <= 1'b1;
            else if (supply_on)
                hiccup <= 1'b0;
        end
    end

    always_comb begin
        gate_en     = (state == ST_RUN);
        startup_cur = (state == ST_RESET) ||
                      (((state == ST_AUTOREC) || (state == ST_LATCHED)) && hiccup);
        fault_code  = code_q;
        seq_state   = state;
    end
endmodule

// File: rtl/psq_checker.sv
module psq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_on,
    input logic       below_off,
    input logic       below_reset,
    input logic       brownout,
    input logic       gate_en,
    input logic [3:0] fault_code,
    input logic [2:0] seq_state
);
    // seq_state: 0 RESET, 1 STOP, 2 RUN, 3 DISCH, 4 AUTOREC, 5 LATCHED

    a_r3_uvlo_to_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd2 && below_off) |=> (seq_state == 3'd0));

    a_r8_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd5 && !below_reset) |=> (seq_state == 3'd5));

    a_r9_bo_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd3 && fault_code == 4'd8 && !brownout) |=> (seq_state == 3'd0));

    a_r7_recover_waits_supply: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd4 && !supply_on) |=> (seq_state != 3'd0));

    a_r2_run_entered_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> ($past(seq_state) == 3'd1));
endmodule

bind prot_seq psq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .supply_on(supply_on), .below_off(below_off),
    .below_reset(below_reset), .brownout(brownout), .gate_en(gate_en),
    .fault_code(fault_code), .seq_state(seq_state)
);

// File: tb/prot_seq_tb.sv
`timescale 1ns/1ps
module prot_seq_tb;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, tick, supply_on, below_off, below_reset, supply_ov, sd_ov, sd_ot;
    logic sd_restart_ok, winding_short, aux_short, cs_low, on_blank_done, brownout, die_hot;
    logic       g_u, s_u, g_l, s_l;
    logic [3:0] c_u, c_l;
    logic [2:0] st_u, st_l;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    prot_seq #(.START_TICKS(4), .CONFIRM_TICKS(3), .AUX_TICKS(6), .BO_LONG_TICKS(8),
               .BO_SHORT_TICKS(3), .BO_SHORT(1'b0), .RECOVER_TICKS(20),
               .LATCHED(1'b0), .CS_CHECK_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_on(supply_on), .below_off(below_off),
        .below_reset(below_reset), .supply_ov(supply_ov), .sd_ov(sd_ov), .sd_ot(sd_ot),
        .sd_restart_ok(sd_restart_ok), .winding_short(winding_short), .aux_short(aux_short),
        .cs_low(cs_low), .on_blank_done(on_blank_done), .brownout(brownout), .die_hot(die_hot),
        .gate_en(g_u), .startup_cur(s_u), .fault_code(c_u), .seq_state(st_u));

    prot_seq #(.START_TICKS(4), .CONFIRM_TICKS(3), .AUX_TICKS(6), .BO_LONG_TICKS(8),
               .BO_SHORT_TICKS(3), .BO_SHORT(1'b1), .RECOVER_TICKS(20),
               .LATCHED(1'b1), .CS_CHECK_EN(1'b0)) u_dut_l (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_on(supply_on), .below_off(below_off),
        .below_reset(below_reset), .supply_ov(supply_ov), .sd_ov(sd_ov), .sd_ot(sd_ot),
        .sd_restart_ok(sd_restart_ok), .winding_short(winding_short), .aux_short(aux_short),
        .cs_low(cs_low), .on_blank_done(on_blank_done), .brownout(brownout), .die_hot(die_hot),
        .gate_en(g_l), .startup_cur(s_l), .fault_code(c_l), .seq_state(st_l));

    // Per fault index: {state_u, code_u, state_l, code_l}
    // index 0 supply_ov, 1 sd_ov, 2 sd_ot, 3 winding, 4 aux, 5 cs_low, 6 die_hot, 7 brownout
    localparam logic [13:0] VEC [8] = '{
        {3'd4, 4'd1, 3'd4, 4'd1},
        {3'd4, 4'd2, 3'd4, 4'd2},
        {3'd4, 4'd3, 3'd5, 4'd3},
        {3'd4, 4'd4, 3'd5, 4'd4},
        {3'd4, 4'd5, 3'd5, 4'd5},
        {3'd3, 4'd6, 3'd2, 4'd0},
        {3'd3, 4'd7, 3'd3, 4'd7},
        {3'd3, 4'd8, 3'd3, 4'd8}
    };
    localparam string VREQ [8] = '{"R6", "R4", "R8", "R6", "R5", "R11", "R6", "R5"};

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_flags(input logic [7:0] v);
        {brownout, die_hot, cs_low, aux_short, winding_short, sd_ot, sd_ov, supply_ov} = v;
    endtask

    task automatic bring_up();
        rst_n = 1'b0; tick = 1'b1; supply_on = 1'b0; below_off = 1'b1; below_reset = 1'b1;
        sd_restart_ok = 1'b1; on_blank_done = 1'b1; set_flags(8'h00);
        step(2);
        chk("R1 state", st_u, 0); chk("R1 gate", g_u, 0);
        chk("R1 startup", s_u, 1); chk("R1 code", c_u, 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 state after release", st_u, 0);
        below_reset = 1'b0; below_off = 1'b0; supply_on = 1'b1;
        step(3);
        chk("R2 still in start delay", st_u, 0);
        step(3);
        chk("R2 running", st_u, 2); chk("R2 gate on", g_u, 1);
        chk("R2 latched variant running", st_l, 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // Table of single-fault vectors
        for (int i = 0; i < 8; i++) begin
            bring_up();
            set_flags(8'(1) << i);
            step(10);
            chk({VREQ[i], " state"}, st_u, int'(VEC[i][13:11]));
            chk({VREQ[i], " code"},  c_u,  int'(VEC[i][10:7]));
            chk({VREQ[i], " latched-variant state"}, st_l, int'(VEC[i][6:4]));
            chk({VREQ[i], " latched-variant code"},  c_l,  int'(VEC[i][3:0]));
            chk({VREQ[i], " gate off"}, g_u, 0);
        end

        // R4: short SD overvoltage pulse ignored
        bring_up();
        sd_ov = 1'b1; step(2); sd_ov = 1'b0; step(5);
        chk("R4 short pulse ignored", st_u, 2);
        chk("R4 short pulse no code", c_u, 0);

        // R2: ticks gate the start delay
        rst_n = 1'b0; tick = 1'b0; set_flags(8'h00); step(1); rst_n = 1'b1;
        below_off = 1'b0; below_reset = 1'b0; supply_on = 1'b1;
        step(10);
        chk("R2 no tick no start", st_u, 0);
        tick = 1'b1; step(6);
        chk("R2 start with tick", st_u, 2);

        // R3: undervoltage in RUN
        bring_up();
        below_off = 1'b1; step(1);
        chk("R3 uvlo reset", st_u, 0); chk("R3 uvlo code kept", c_u, 0);
        chk("R3 uvlo startup", s_u, 1);

        // R7 / R13: auto-recovery with supply hiccup
        bring_up();
        supply_ov = 1'b1; step(2); supply_ov = 1'b0;
        chk("R7 in autorec", st_u, 4);
        chk("R13 no startup before hiccup", s_u, 0);
        below_off = 1'b1; supply_on = 1'b0; step(2);
        chk("R13 startup during hiccup", s_u, 1);
        step(30);
        chk("R7 waits for supply", st_u, 4);
        below_off = 1'b0; supply_on = 1'b1; step(2);
        chk("R7 restart", st_u, 0);

        // R7 / R8: overtemperature hysteresis and latch release
        bring_up();
        sd_ot = 1'b1; step(6); sd_ot = 1'b0; sd_restart_ok = 1'b0;
        step(30);
        chk("R7 ot waits restart level", st_u, 4);
        sd_restart_ok = 1'b1; step(2);
        chk("R7 ot restart", st_u, 0);
        chk("R8 still latched", st_l, 5);
        below_off = 1'b1; supply_on = 1'b0; step(3);
        chk("R8 hiccup keeps latch", st_l, 5);
        chk("R13 latched startup hiccup", s_l, 1);
        below_reset = 1'b1; step(2);
        chk("R8 reset releases latch", st_l, 0);

        // R9: brown-out exit bypasses hiccup
        bring_up();
        brownout = 1'b1; step(10);
        chk("R9 brown-out discharge", st_u, 3);
        brownout = 1'b0; step(1);
        chk("R9 bypass to reset", st_u, 0);
        chk("R9 startup current", s_u, 1);

        // R10: discharge waits for off-level
        bring_up();
        die_hot = 1'b1; step(3); die_hot = 1'b0; step(5);
        chk("R10 discharge holds", st_u, 3);
        below_off = 1'b1; step(1);
        chk("R10 hiccup to reset", st_u, 0);

        // R11: CS short gated by blanking
        bring_up();
        on_blank_done = 1'b0; cs_low = 1'b1; step(5);
        chk("R11 blanked cs ignored", st_u, 2);
        on_blank_done = 1'b1; step(2);
        chk("R11 cs short taken", st_u, 3); chk("R11 cs code", c_u, 6);

        // R12: precedence
        bring_up();
        winding_short = 1'b1; supply_ov = 1'b1; step(2);
        chk("R12 winding wins", c_u, 4); chk("R12 latched winding", st_l, 5);
        bring_up();
        cs_low = 1'b1; die_hot = 1'b1; step(2);
        chk("R12 cs over die", c_u, 6);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule